// File: doc/BRIEF.md
# Descriptor Ring Engine with Completion Shadow Pointer

This block passes queued work between a host and an on-chip processor through two index-addressed rings. On the inbound ring, the host writes a request address and a size into a slot. It then advances a write pointer to the last slot it filled. The engine walks its own read index up to that pointer, one slot per cycle. Each slot it reaches is presented to the processor-side consumer.

When the consumer reports that a request is done, the engine writes a completion word into the next slot of the outbound ring. It publishes that slot's index in a shadow register and flags an interrupt. The host never pops a queue. It keeps its own last-read index N, compares N with the shadow, and reads slot N+1 whenever the two differ. Both rings wrap to zero at a count the host programs.

A pair of message registers carries non-queued commands. The host writes a command word for the processor. The processor answers by writing the same value back.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, the configuration register reads DEPTH (16 by default). The write pointer and the shadow both read DEPTH-1. The cause register reads 0, and `irq`, `cons_valid` and `hst_rvalid` are low.
- R2: A read strobe at `hst_re` is answered two clock edges later, with `hst_rvalid` high for one cycle and the data on `hst_rdata`. Addresses 3, 4 and 12–15 read as 0.
- R3: Writing address 0 sets the ring count from bits 7:0 (legal values 1..DEPTH). The same write resets the write pointer, the engine's internal read index and the outbound index to count-1, so the next slot used on either ring is 0. Reading address 0 returns the count.
- R4: Slot loading works as follows. Address 2 selects the inbound slot. A write to address 3 stores the request address of that slot; its low 5 bits are dropped, because requests are 32-byte aligned. A write to address 4 stores the size (low SIZE_W bits).
- R5: While the internal read index differs from the write pointer (address 1), the engine advances the index by one slot per cycle, wrapping to 0 after count-1. Each advance presents the slot on `cons_valid`/`cons_idx`/`cons_addr`/`cons_size` one cycle later, so the first unit appears on the second edge after the pointer write. The engine stops when the index equals the pointer.
- R6: Each `cmpl_valid` cycle advances the outbound index, wrapping after count-1. It writes `0x80000000 | cmpl_tag` into that slot and makes the index readable as the shadow (address 5). Address 6 selects an outbound slot, and address 7 reads its word.
- R7: Cause bit 0 (address 8) is set by a completion and cleared by writing 1 to it. A completion in the same cycle as the clear leaves the bit set.
- R8: `irq` is the registered AND of cause bit 0 and enable bit 0 (address 9). It follows them one cycle later.
- R9: A host write to address 10 drives the word onto `cpu_msg` and pulses `cpu_msg_new` high for the following cycle. The word reads back at address 10.
- R10: A `cpu_reply_we` cycle stores `cpu_reply`, which the host reads at address 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_re | input | 1 | Host register read strobe |
| hst_addr | input | 4 | Host register word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| hst_rvalid | output | 1 | Read data valid, two edges after the strobe |
| irq | output | 1 | Outbound interrupt |
| cons_valid | output | 1 | Inbound slot presented to the consumer |
| cons_idx | output | IDX_W | Index of the presented slot |
| cons_addr | output | 32 | Request address, 32-byte aligned |
| cons_size | output | SIZE_W | Request size |
| cmpl_valid | input | 1 | Consumer reports one completion |
| cmpl_tag | input | TAG_W | Request index carried in the completion word |
| cpu_msg | output | 32 | Host-to-processor message word |
| cpu_msg_new | output | 1 | One-cycle pulse after a new message |
| cpu_reply_we | input | 1 | Processor writes its reply |
| cpu_reply | input | 32 | Processor reply word |

## Verification
The checks depend on when each result is due. Register reads land two edges after the strobe. Consumer slots start on the second edge after the write-pointer write, then come one per cycle. Shadow, cause and outbound words are updated on the completion edge itself. `irq` and `cpu_msg_new` follow one edge after their cause. The bench drives every input just after a rising edge and samples just after the edge on which the result is due. For `irq` and `cpu_msg_new`, it also samples one edge before, to confirm the output has not moved early. A scoreboard queue receives the expected slots when the pointer is posted. A monitor drains it on falling edges, so ordering, wrap-around and surplus outputs are all caught.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic [3:0] {
    RA_CFG     = 4'd0,
    RA_WPTR    = 4'd1,
    RA_INSEL   = 4'd2,
    RA_INADDR  = 4'd3,
    RA_INSIZE  = 4'd4,
    RA_SHADOW  = 4'd5,
    RA_OUTSEL  = 4'd6,
    RA_OUTWORD = 4'd7,
    RA_CAUSE   = 4'd8,
    RA_IRQEN   = 4'd9,
    RA_TOCPU   = 4'd10,
    RA_FROMCPU = 4'd11
  } reg_addr_e;

  localparam logic [31:0] HOST_BITS = 32'h8000_0000;
  localparam int          ALIGN_SH  = 5;
endpackage

// File: rtl/dr_inbound.sv
module dr_inbound
  import desc_ring_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_valid,
  input  logic [IDX_W-1:0]  init_idx,
  input  logic [IDX_W-1:0]  cnt_m1,
  input  logic [IDX_W-1:0]  wptr,
  input  logic              wr_addr_en,
  input  logic              wr_size_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [31:0]       wr_data,
  output logic              cons_valid,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [31:0]       cons_addr,
  output logic [SIZE_W-1:0] cons_size
);
  localparam int AW = 32 - ALIGN_SH;

  logic [AW-1:0]     addr_mem [DEPTH];
  logic [SIZE_W-1:0] size_mem [DEPTH];
  logic [AW-1:0]     addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  nxt_idx;
  logic              pending;

  always_comb begin
    nxt_idx = (rd_idx == cnt_m1) ? '0 : rd_idx + 1'b1;
    pending = (rd_idx != wptr);
  end

  always_ff @(posedge clk) begin
    if (wr_addr_en) addr_mem[wr_sel] <= wr_data[31:ALIGN_SH];
  end

  always_ff @(posedge clk) begin
    if (wr_size_en) size_mem[wr_sel] <= wr_data[SIZE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (pending) begin
      addr_q <= addr_mem[nxt_idx];
      size_q <= size_mem[nxt_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx     <= IDX_W'(DEPTH - 1);
      cons_idx   <= '0;
      cons_valid <= 1'b0;
    end else if (init_valid) begin
      rd_idx     <= init_idx;
      cons_valid <= 1'b0;
    end else begin
      cons_valid <= pending;
      if (pending) begin
        rd_idx   <= nxt_idx;
        cons_idx <= nxt_idx;
      end
    end
  end

  assign cons_addr = {addr_q, {ALIGN_SH{1'b0}}};
  assign cons_size = size_q;
endmodule

// File: rtl/dr_outbound.sv
module dr_outbound
  import desc_ring_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_valid,
  input  logic [IDX_W-1:0] init_idx,
  input  logic [IDX_W-1:0] cnt_m1,
  input  logic             cmpl_valid,
  input  logic [TAG_W-1:0] cmpl_tag,
  input  logic             cause_clr,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [IDX_W-1:0] shadow,
  output logic             cause,
  output logic [31:0]      rd_word
);
  logic [31:0]      out_mem [DEPTH];
  logic [IDX_W-1:0] nxt_idx;

  assign nxt_idx = (shadow == cnt_m1) ? '0 : shadow + 1'b1;

  always_ff @(posedge clk) begin
    if (cmpl_valid) out_mem[nxt_idx] <= HOST_BITS | 32'(cmpl_tag);
    rd_word <= out_mem[rd_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= IDX_W'(DEPTH - 1);
      cause  <= 1'b0;
    end else begin
      if (init_valid)      shadow <= init_idx;
      else if (cmpl_valid) shadow <= nxt_idx;
      if (cmpl_valid)      cause  <= 1'b1;
      else if (cause_clr)  cause  <= 1'b0;
    end
  end
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import desc_ring_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int SIZE_W = 16,
  parameter  int TAG_W  = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [3:0]        hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              hst_rvalid,
  output logic              irq,
  output logic              cons_valid,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [31:0]       cons_addr,
  output logic [SIZE_W-1:0] cons_size,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  output logic [31:0]       cpu_msg,
  output logic              cpu_msg_new,
  input  logic              cpu_reply_we,
  input  logic [31:0]       cpu_reply
);
  logic [IDX_W-1:0] cnt_m1, wptr, in_sel, out_sel, shadow, new_m1;
  logic             cause, irq_en, cfg_we, cause_clr;
  logic [31:0]      out_word, msg_from_cpu, rd_mux;
  logic [3:0]       rd_sel_q;
  logic             rd_pend_q;

  assign cfg_we    = hst_we && (hst_addr == RA_CFG);
  assign new_m1    = IDX_W'(hst_wdata[7:0] - 8'd1);
  assign cause_clr = hst_we && (hst_addr == RA_CAUSE) && hst_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_m1       <= IDX_W'(DEPTH - 1);
      wptr         <= IDX_W'(DEPTH - 1);
      in_sel       <= '0;
      out_sel      <= '0;
      irq_en       <= 1'b0;
      cpu_msg      <= '0;
      cpu_msg_new  <= 1'b0;
      msg_from_cpu <= '0;
    end else begin
      cpu_msg_new <= 1'b0;
      if (cfg_we) begin
        cnt_m1 <= new_m1;
        wptr   <= new_m1;
      end
      if (hst_we) begin
        case (hst_addr)
          RA_WPTR:   wptr    <= hst_wdata[IDX_W-1:0];
          RA_INSEL:  in_sel  <= hst_wdata[IDX_W-1:0];
          RA_OUTSEL: out_sel <= hst_wdata[IDX_W-1:0];
          RA_IRQEN:  irq_en  <= hst_wdata[0];
          RA_TOCPU: begin
            cpu_msg     <= hst_wdata;
            cpu_msg_new <= 1'b1;
          end
          default: ;
        endcase
      end
      if (cpu_reply_we) msg_from_cpu <= cpu_reply;
    end
  end

  dr_inbound #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_in (
    .clk        (clk),
    .rst        (rst),
    .init_valid (cfg_we),
    .init_idx   (new_m1),
    .cnt_m1     (cnt_m1),
    .wptr       (wptr),
    .wr_addr_en (hst_we && (hst_addr == RA_INADDR)),
    .wr_size_en (hst_we && (hst_addr == RA_INSIZE)),
    .wr_sel     (in_sel),
    .wr_data    (hst_wdata),
    .cons_valid (cons_valid),
    .cons_idx   (cons_idx),
    .cons_addr  (cons_addr),
    .cons_size  (cons_size)
  );

  dr_outbound #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .init_valid (cfg_we),
    .init_idx   (new_m1),
    .cnt_m1     (cnt_m1),
    .cmpl_valid (cmpl_valid),
    .cmpl_tag   (cmpl_tag),
    .cause_clr  (cause_clr),
    .rd_sel     (out_sel),
    .shadow     (shadow),
    .cause      (cause),
    .rd_word    (out_word)
  );

  always_comb begin
    case (rd_sel_q)
      RA_CFG:     rd_mux = 32'(cnt_m1) + 32'd1;
      RA_WPTR:    rd_mux = 32'(wptr);
      RA_INSEL:   rd_mux = 32'(in_sel);
      RA_SHADOW:  rd_mux = 32'(shadow);
      RA_OUTSEL:  rd_mux = 32'(out_sel);
      RA_OUTWORD: rd_mux = out_word;
      RA_CAUSE:   rd_mux = {31'b0, cause};
      RA_IRQEN:   rd_mux = {31'b0, irq_en};
      RA_TOCPU:   rd_mux = cpu_msg;
      RA_FROMCPU: rd_mux = msg_from_cpu;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_sel_q   <= '0;
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
      irq        <= 1'b0;
    end else begin
      rd_pend_q  <= hst_re;
      rd_sel_q   <= hst_addr;
      hst_rvalid <= rd_pend_q;
      if (rd_pend_q) hst_rdata <= rd_mux;
      irq <= cause & irq_en;
    end
  end
endmodule

// File: rtl/dr_sva.sv
module dr_sva
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hst_we,
  input logic             hst_re,
  input logic [3:0]       hst_addr,
  input logic             hst_rvalid,
  input logic             cons_valid,
  input logic [IDX_W-1:0] cons_idx,
  input logic [IDX_W-1:0] cnt_m1,
  input logic             cmpl_valid,
  input logic             cause,
  input logic             irq_en,
  input logic             irq,
  input logic             cpu_msg_new
);
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    hst_rvalid |-> $past(hst_re, 2));

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    cons_valid |-> cons_idx <= cnt_m1);

  a_r5_in_order: assert property (@(posedge clk) disable iff (rst)
    (cons_valid && $past(cons_valid)) |->
      cons_idx == (($past(cons_idx) == $past(cnt_m1)) ? '0 : IDX_W'($past(cons_idx) + 1'b1)));

  a_r7_cause_set: assert property (@(posedge clk) disable iff (rst)
    cmpl_valid |=> cause);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (!irq_en || !cause) |=> !irq);

  a_r9_msg_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_msg_new |-> ($past(hst_we) && $past(hst_addr) == RA_TOCPU));
endmodule

bind desc_ring_engine dr_sva #(.IDX_W(IDX_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .hst_we      (hst_we),
  .hst_re      (hst_re),
  .hst_addr    (hst_addr),
  .hst_rvalid  (hst_rvalid),
  .cons_valid  (cons_valid),
  .cons_idx    (cons_idx),
  .cnt_m1      (cnt_m1),
  .cmpl_valid  (cmpl_valid),
  .cause       (cause),
  .irq_en      (irq_en),
  .irq         (irq),
  .cpu_msg_new (cpu_msg_new)
);

// File: tb/sim_desc_ring_engine.sv
module sim_desc_ring_engine;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 0, hst_re = 0;
  logic [3:0]  hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid, irq, cons_valid;
  logic [IDX_W-1:0] cons_idx;
  logic [31:0] cons_addr;
  logic [15:0] cons_size;
  logic        cmpl_valid = 0;
  logic [15:0] cmpl_tag = 0;
  logic [31:0] cpu_msg;
  logic        cpu_msg_new;
  logic        cpu_reply_we = 0;
  logic [31:0] cpu_reply = 0;

  always #2 clk = ~clk;

  desc_ring_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .irq(irq),
    .cons_valid(cons_valid), .cons_idx(cons_idx), .cons_addr(cons_addr),
    .cons_size(cons_size), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .cpu_msg(cpu_msg), .cpu_msg_new(cpu_msg_new), .cpu_reply_we(cpu_reply_we),
    .cpu_reply(cpu_reply));

  typedef struct packed {
    logic [7:0]  idx;
    logic [31:0] addr;
    logic [15:0] size;
  } item_t;

  item_t exp_q[$];
  int total = 0, fails = 0;
  bit done = 0;
  int m_cnt = DEPTH, m_rd = DEPTH - 1, m_out = DEPTH - 1;
  logic [31:0] m_addr [DEPTH];
  logic [15:0] m_size [DEPTH];

  function automatic int wrapn(int i);
    return (i == m_cnt - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hst_we = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    hst_re = 1; hst_addr = a;
    @(posedge clk); #1;
    hst_re = 0;
    @(posedge clk); #1;
    chk(hst_rvalid === 1'b1, "R2", "rvalid two edges after strobe", {31'b0, hst_rvalid}, 1);
    d = hst_rdata;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, req, $sformatf("read addr %0d", a), v, exp);
  endtask

  task automatic fill(input int i, input logic [31:0] a, input logic [15:0] s);
    wr(4'd2, i);
    wr(4'd3, a);
    wr(4'd4, {16'h0, s});
    m_addr[i] = a & 32'hFFFF_FFE0;
    m_size[i] = s;
  endtask

  task automatic post(input int w);
    while (m_rd != w) begin
      m_rd = wrapn(m_rd);
      exp_q.push_back({8'(m_rd), m_addr[m_rd], m_size[m_rd]});
    end
    wr(4'd1, w);
  endtask

  task automatic complete(input logic [15:0] tag);
    @(posedge clk); #1;
    cmpl_valid = 1; cmpl_tag = tag;
    @(posedge clk); #1;
    cmpl_valid = 0;
    m_out = wrapn(m_out);
  endtask

  // Scoreboard monitor for the consumer side (R5, R4)
  always @(negedge clk) begin
    if (!rst && cons_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5", "unexpected consumer slot", 32'(cons_idx), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(32'(cons_idx) == 32'(e.idx), "R5", "slot index", 32'(cons_idx), 32'(e.idx));
        chk(cons_addr === e.addr, "R4", "slot address", cons_addr, e.addr);
        chk(cons_size === e.size, "R4", "slot size", 32'(cons_size), 32'(e.size));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq === 0, "R1", "irq after reset", {31'b0, irq}, 0);
    chk(cons_valid === 0, "R1", "cons_valid after reset", {31'b0, cons_valid}, 0);
    chk(hst_rvalid === 0, "R1", "rvalid after reset", {31'b0, hst_rvalid}, 0);
    rd_chk(4'd0, DEPTH, "R1");
    rd_chk(4'd1, DEPTH - 1, "R1");
    rd_chk(4'd5, DEPTH - 1, "R1");
    rd_chk(4'd8, 0, "R1");
    // R2 write-only and unmapped addresses read 0
    fill(3, 32'h1234_5678, 16'h55);
    rd_chk(4'd3, 0, "R2");
    rd_chk(4'd14, 0, "R2");

    // R4/R5 first batch with the reset count
    for (int i = 0; i < 5; i++) fill(i, 32'h1000_0000 + i * 32'h40 + 32'h1F, 16'(100 + i));
    post(4);
    @(posedge clk); #1;
    chk(cons_valid === 1, "R5", "first slot due second edge after post", {31'b0, cons_valid}, 1);
    repeat (10) @(posedge clk);
    chk(exp_q.size() == 0, "R5", "batch drained", exp_q.size(), 0);

    // R3 count change resets all pointers
    wr(4'd0, 5);
    m_cnt = 5; m_rd = 4; m_out = 4;
    rd_chk(4'd0, 5, "R3");
    rd_chk(4'd1, 4, "R3");
    rd_chk(4'd5, 4, "R3");
    for (int i = 0; i < 5; i++) fill(i, 32'hA000_0000 + i * 32'h100, 16'(16'h2000 + i));
    post(2);
    repeat (6) @(posedge clk);
    post(1); // wraps through 3,4,0,1
    repeat (8) @(posedge clk);
    chk(exp_q.size() == 0, "R5", "wrapped batch drained", exp_q.size(), 0);
    chk(cons_valid === 0, "R5", "engine idle at pointer", {31'b0, cons_valid}, 0);

    // R6/R7/R8 completion path
    wr(4'd9, 1);
    complete(16'h0012);
    chk(irq === 0, "R8", "irq not yet raised on completion edge", {31'b0, irq}, 0);
    @(posedge clk); #1;
    chk(irq === 1, "R8", "irq one edge after cause", {31'b0, irq}, 1);
    rd_chk(4'd5, 0, "R6");
    rd_chk(4'd8, 1, "R7");
    wr(4'd6, 0);
    rd_chk(4'd7, 32'h8000_0012, "R6");
    wr(4'd8, 1);
    rd_chk(4'd8, 0, "R7");
    chk(irq === 0, "R8", "irq dropped after clear", {31'b0, irq}, 0);

    for (int t = 1; t <= 5; t++) complete(16'(t));
    rd_chk(4'd5, 0, "R6");
    wr(4'd6, 4);
    rd_chk(4'd7, 32'h8000_0004, "R6");
    wr(4'd6, 0);
    rd_chk(4'd7, 32'h8000_0005, "R6");

    // R7 set wins over clear in the same cycle
    wr(4'd8, 1);
    @(posedge clk); #1;
    hst_we = 1; hst_addr = 4'd8; hst_wdata = 1; cmpl_valid = 1; cmpl_tag = 16'h7;
    @(posedge clk); #1;
    hst_we = 0; cmpl_valid = 0;
    m_out = wrapn(m_out);
    rd_chk(4'd8, 1, "R7");
    rd_chk(4'd5, 1, "R6");
    // R8 enable off masks irq
    wr(4'd9, 0);
    @(posedge clk); #1;
    chk(irq === 0, "R8", "irq masked by enable", {31'b0, irq}, 0);

    // R9 message to processor
    wr(4'd10, 32'hCAFE_0001);
    chk(cpu_msg_new === 1, "R9", "pulse after write", {31'b0, cpu_msg_new}, 1);
    chk(cpu_msg === 32'hCAFE_0001, "R9", "message word", cpu_msg, 32'hCAFE_0001);
    @(posedge clk); #1;
    chk(cpu_msg_new === 0, "R9", "pulse one cycle", {31'b0, cpu_msg_new}, 0);
    rd_chk(4'd10, 32'hCAFE_0001, "R9");
    // R10 processor reply
    @(posedge clk); #1;
    cpu_reply_we = 1; cpu_reply = 32'hCAFE_0001;
    @(posedge clk); #1;
    cpu_reply_we = 0;
    rd_chk(4'd11, 32'hCAFE_0001, "R10");

    repeat (4) @(posedge clk);
    report();
  end
endmodule